// File: doc/BRIEF.md
# Port change interrupt generator

This block raises an active-low interrupt flag when any line of a wide input port changes. It holds a reference snapshot of the port. The flag is asserted while any synchronized pin differs from that snapshot. Because the flag is a level comparison, it withdraws by itself when the pins drift back to the snapshot value.

A host acknowledges the change by reading or writing the port. The serial front end supplies these as a read strobe and a write strobe. A clear reloads the snapshot from the live pins. A rising edge of the read strobe causes a clear. The falling edge of the write strobe always causes a clear, and its rising edge also does when the parameter `WR_CLR_RISE` is set. After each clear there is a one-cycle blanking window. During that window the flag is held inactive and the snapshot keeps tracking the pins, so changes inside the window are absorbed. Pin synchronization and the serial protocol are handled outside this block.

Top module: `port_chg_irq`

## Requirements
- R1: While `rst_ni` is low and in the cycles right after its release, `irq_no` is 1, whatever the pin values are. The first clock after release loads the snapshot from the pins.
- R2: A change on any single pin, in either direction, drives `irq_no` to 0 on the first rising clock edge that samples the changed pins.
- R3: When the pins return to the snapshot value, `irq_no` goes back to 1 on the next rising clock edge.
- R4: A 0-to-1 transition of `rd_stb_i` clears the interrupt: `irq_no` is 1 after that edge, and the snapshot becomes the current pin value. Holding `rd_stb_i` at 1 does not clear again, and its 1-to-0 transition does not clear.
- R5: A 1-to-0 transition of `wr_stb_i` always clears the interrupt and reloads the snapshot. A 0-to-1 transition of `wr_stb_i` also does so when `WR_CLR_RISE`=1, which is the default.
- R6: For the one clock cycle after a clear, `irq_no` stays 1. Pin values present during that cycle become the snapshot, so a change made in that cycle never raises the interrupt.
- R7: After the blanking cycle, a new change away from the reloaded snapshot raises the interrupt again, as in R2.
- R8: While the pins differ from the snapshot and no clear edge occurs, `irq_no` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | WIDTH | Synchronized port pin levels |
| rd_stb_i | input | 1 | Read-from-port strobe |
| wr_stb_i | input | 1 | Write-to-port strobe |
| irq_no | output | 1 | Interrupt, active low |

## Verification
The bench toggles every one of the 24 bits, in both directions and from several base patterns, and then restores it. A comparator that dropped a bit would never flag that bit, and one that latched the flag would not withdraw after the restore. Read and write strobes are driven as short pulses and as held levels. This exposes a design that clears on a level instead of an edge, or that ignores the falling write edge. Pins are also changed inside the blanking cycle and again just after it. A design with no blanking window, or with a window that never ends, would flag the first change or miss the second.

// File: rtl/port_chg_pkg.sv
package port_chg_pkg;
  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2
  } edge_sel_e;
endpackage

// File: rtl/pci_edge_det.sv
module pci_edge_det #(
  parameter port_chg_pkg::edge_sel_e SEL = port_chg_pkg::EDGE_RISE
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  output logic hit_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= stb_i;
  end

  generate
    if (SEL == port_chg_pkg::EDGE_RISE) begin : g_rise
      assign hit_o = stb_i & ~prev_q;
    end else if (SEL == port_chg_pkg::EDGE_FALL) begin : g_fall
      assign hit_o = ~stb_i & prev_q;
    end else begin : g_both
      assign hit_o = stb_i ^ prev_q;
    end
  endgenerate
endmodule

// File: rtl/pci_mismatch.sv
module pci_mismatch #(
  parameter int WIDTH = 24
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             any_o
);
  logic [WIDTH-1:0] diff;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign diff[i] = a_i[i] ^ b_i[i];
  end

  assign any_o = |diff;
endmodule

// File: rtl/pci_snapshot.sv
module pci_snapshot #(
  parameter int WIDTH = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] pins_i,
  output logic [WIDTH-1:0] ref_o,
  output logic             blank_o
);
  logic [WIDTH-1:0] ref_q;
  logic             blank_q;

  // reset leaves blank set so the first edge captures the pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q   <= '0;
      blank_q <= 1'b1;
    end else begin
      if (load_i || blank_q) ref_q <= pins_i;
      blank_q <= load_i;
    end
  end

  assign ref_o   = ref_q;
  assign blank_o = blank_q;
endmodule

// File: rtl/port_chg_irq.sv
module port_chg_irq #(
  parameter int WIDTH       = 24,
  parameter bit WR_CLR_RISE = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pins_i,
  input  logic             rd_stb_i,
  input  logic             wr_stb_i,
  output logic             irq_no
);
  import port_chg_pkg::*;

  localparam edge_sel_e WR_SEL = WR_CLR_RISE ? EDGE_BOTH : EDGE_FALL;

  logic             rd_hit, wr_hit, clr;
  logic [WIDTH-1:0] ref_w;
  logic             blank, mism;
  logic             act_q;

  pci_edge_det #(.SEL(EDGE_RISE)) u_rd_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stb_i (rd_stb_i),
    .hit_o (rd_hit)
  );

  pci_edge_det #(.SEL(WR_SEL)) u_wr_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .stb_i (wr_stb_i),
    .hit_o (wr_hit)
  );

  assign clr = rd_hit | wr_hit;

  pci_snapshot #(.WIDTH(WIDTH)) u_snap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (clr),
    .pins_i (pins_i),
    .ref_o  (ref_w),
    .blank_o(blank)
  );

  pci_mismatch #(.WIDTH(WIDTH)) u_cmp (
    .a_i  (pins_i),
    .b_i  (ref_w),
    .any_o(mism)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= mism & ~clr & ~blank;
  end

  assign irq_no = ~act_q;
endmodule

// File: rtl/port_chg_irq_chk.sv
module port_chg_irq_chk #(
  parameter int WIDTH       = 24,
  parameter bit WR_CLR_RISE = 1'b1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] pins_i,
  input logic             rd_stb_i,
  input logic             wr_stb_i,
  input logic             irq_no
);
  always_comb begin
    if (!rst_ni) assert_reset_idle_R1: assert (irq_no == 1'b1);
  end

  assert_rd_rise_clears_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && !$past(rd_stb_i)) |=> irq_no);

  assert_wr_fall_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_stb_i && $past(wr_stb_i)) |=> irq_no);

  assert_wr_rise_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (WR_CLR_RISE && wr_stb_i && !$past(wr_stb_i)) |=> irq_no);

  // a clear reaches the window: flag stays high one more cycle
  assert_window_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_stb_i && !$past(rd_stb_i)) |=> ##1 irq_no);

  // steady pins with no flag keep the flag off
  assert_steady_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_no && $stable(pins_i)) |=> irq_no);

  // asserted flag persists while pins and strobes are steady
  assert_level_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_no && $stable(pins_i) && $stable(rd_stb_i) && $stable(wr_stb_i)) |=> !irq_no);
endmodule

bind port_chg_irq port_chg_irq_chk #(.WIDTH(WIDTH), .WR_CLR_RISE(WR_CLR_RISE)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pins_i  (pins_i),
  .rd_stb_i(rd_stb_i),
  .wr_stb_i(wr_stb_i),
  .irq_no  (irq_no)
);

// File: tb/sim_port_chg_irq.sv
`timescale 1ns/1ps
module sim_port_chg_irq;
  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] pins = '0;
  logic         rd = 1'b0, wr = 1'b0;
  logic         irq_n;

  int total = 0, bad = 0;

  // model state
  logic [W-1:0] m_ref;
  logic         m_blank, m_rdp, m_wrp;

  always #2.5 clk = ~clk;

  port_chg_irq #(.WIDTH(W), .WR_CLR_RISE(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pins_i(pins),
    .rd_stb_i(rd), .wr_stb_i(wr), .irq_no(irq_n)
  );

  task automatic check(input logic exp, input string tag);
    total++;
    if (irq_n !== exp) begin
      bad++;
      $display("FAIL %s: irq_no=%b expected=%b", tag, irq_n, exp);
    end
  endtask

  // apply inputs now (at negedge), advance one posedge, compare at next negedge
  task automatic tick(input logic [W-1:0] p, input logic r, input logic w,
                      input logic exp_fixed, input bit use_fixed, input string tag);
    logic clr, act;
    pins = p; rd = r; wr = w;
    clr = (r & ~m_rdp) | (w ^ m_wrp);
    act = (p != m_ref) && !clr && !m_blank;
    if (clr || m_blank) m_ref = p;
    m_blank = clr; m_rdp = r; m_wrp = w;
    @(negedge clk);
    check(~act, tag);
    if (use_fixed) check(exp_fixed, tag);
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog: irq_no=%b expected=done", irq_n);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] base;
    logic [W-1:0] bases [4];
    bases[0] = 24'h000000; bases[1] = 24'hFFFFFF;
    bases[2] = 24'hA5C33C; bases[3] = 24'h0F0F0F;

    // R1: reset with nonzero pins
    pins = 24'hA5A5A5;
    repeat (3) @(negedge clk);
    check(1'b1, "R1 in reset");
    rst_n = 1'b1;
    m_ref = '0; m_blank = 1'b1; m_rdp = 1'b0; m_wrp = 1'b0;
    tick(24'hA5A5A5, 0, 0, 1'b1, 1, "R1 after release");
    tick(24'hA5A5A5, 0, 0, 1'b1, 1, "R1 settled");

    // R2/R3/R8 sweep over every bit from several bases
    for (int k = 0; k < 4; k++) begin
      base = bases[k];
      tick(base, 0, 1, 1'b1, 1, "R5 rebase rise");
      tick(base, 0, 0, 1'b1, 1, "R5 rebase fall");
      tick(base, 0, 0, 1'b1, 1, "R6 rebase window");
      for (int b = 0; b < W; b++) begin
        tick(base ^ (24'd1 << b), 0, 0, 1'b0, 1, "R2 single bit");
        tick(base ^ (24'd1 << b), 0, 0, 1'b0, 1, "R8 hold");
        tick(base, 0, 0, 1'b1, 1, "R3 revert");
      end
    end

    base = 24'h123456;
    tick(base, 1, 0, 1'b1, 1, "R4 rebase");
    tick(base, 0, 0, 1'b1, 1, "R4 rebase low");
    tick(base, 0, 0, 1'b1, 1, "R6 idle");

    // R4: read edge clears, held and falling do not
    tick(base ^ 24'h000010, 0, 0, 1'b0, 1, "R2 change");
    tick(base ^ 24'h000010, 1, 0, 1'b1, 1, "R4 rd rise clears");
    tick(base ^ 24'h000010, 1, 0, 1'b1, 1, "R4 held quiet");
    tick(base ^ 24'h000030, 1, 0, 1'b0, 1, "R4 rd held no clear");
    tick(base ^ 24'h000030, 0, 0, 1'b0, 1, "R4 rd fall no clear");
    tick(base ^ 24'h000010, 0, 0, 1'b1, 1, "R3 back to snapshot");

    // R5: write rise and fall
    tick(base ^ 24'h800000, 0, 0, 1'b0, 1, "R2 msb change");
    tick(base ^ 24'h800000, 0, 1, 1'b1, 1, "R5 wr rise clears");
    tick(base ^ 24'h800000, 0, 1, 1'b1, 1, "R6 window");
    tick(base ^ 24'h800001, 0, 1, 1'b0, 1, "R7 change with wr high");
    tick(base ^ 24'h800001, 0, 0, 1'b1, 1, "R5 wr fall clears");
    tick(base ^ 24'h800001, 0, 0, 1'b1, 1, "R5 snapshot reloaded");

    // R6/R7: change inside window absorbed, later change detected
    base = base ^ 24'h800001;
    tick(base ^ 24'h000100, 0, 0, 1'b0, 1, "R2 pre");
    tick(base ^ 24'h000100, 1, 0, 1'b1, 1, "R4 clear");
    tick(base ^ 24'h00FF00, 0, 0, 1'b1, 1, "R6 change in window");
    tick(base ^ 24'h00FF00, 0, 0, 1'b1, 1, "R6 absorbed");
    tick(base ^ 24'h00FF00, 0, 0, 1'b1, 1, "R6 still absorbed");
    tick(base ^ 24'h01FF00, 0, 0, 1'b0, 1, "R7 detected again");
    tick(base ^ 24'h00FF00, 0, 0, 1'b1, 1, "R3 revert");

    // short pulses back to back
    for (int i = 0; i < 8; i++) begin
      tick(base ^ (24'h5 << i), i[0], ~i[0], 1'b0, 0, "R5 pulse mix");
      tick(base ^ (24'h5 << i), 0, 0, 1'b0, 0, "R4 pulse mix");
      tick(base ^ (24'h7 << i), 0, 0, 1'b0, 0, "R7 pulse mix");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule